// File: doc/BRIEF.md
# Handshake Byte Receiver with Stall Watchdog

This block sits between an asynchronous byte source and a processor register port. The source puts a byte on its data lines and raises a valid strobe. The block brings the strobe into its own clock domain and captures the byte. It then answers on a reply line and sets a ready flag that software polls. The reply stays asserted until software has taken the byte and cleared the flag, so the next byte cannot start early. This gives flow control one byte at a time without any buffering.

Each non-idle phase of the handshake is watched by a cycle counter. A phase can stall because the source never drops its strobe or because software never clears the flag. When a phase lasts the programmed number of cycles, a sticky alarm is raised. An interrupt enable lets the ready flag and the alarm drive an interrupt request, so the block works in both polled and interrupt-driven modes. A build parameter inverts the reply line, which gives a ready-for-data line for a source that waits for the receiver to ask first. In that mode only the idle level of the reply changes.

Top module: `hsk_rx_if`

## Requirements
- R1: After reset the internal accepted state is low (dev_ack_o = 0 when DEST_INIT = 0), the flag, alarm and interrupt enable are 0, and irq_o and alarm_o are 0.
- R2: The byte on dev_data_i is captured into the data register, and the reply asserts, on the 4th rising clock edge after dev_valid_i rises. The reply is still deasserted after the 3rd edge.
- R3: The ready flag (status bit 0 at address 1) is set on the same edge that captures the byte.
- R4: While the flag is set, the reply stays asserted and the data register does not change, even if the source drops the strobe or presents a new byte with the strobe high.
- R5: Writing address 1 with bit 0 = 1 clears the flag, and the reply then deasserts on the following clock edge.
- R6: If the strobe is still high when the flag is cleared, the reply deasserts but no byte is captured until the strobe has been seen low and then high again.
- R7: The alarm (status bit 1, output alarm_o) sets when one non-idle handshake phase lasts TIMEOUT_CYC clock edges. It never sets while the block is idle or while bytes flow normally.
- R8: The alarm stays set until address 1 is written with bit 1 = 1. Clearing the flag alone leaves it set.
- R9: Writing address 1 loads the interrupt enable from bit 2. irq_o is high exactly when the enable is set and either the flag or the alarm is set.
- R10: With DEST_INIT = 1 the reply line is the complement of the accepted state: it is high (ready for data) after reset and low while a captured byte waits.
- R11: A read at address 0 returns the data register, and a read at address 1 returns {enable, alarm, flag} in bits 2..0 with the higher bits 0. cpu_rdata_o is 0 unless a read is selected. Writes to address 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dev_data_i | input | DW | Byte from the source |
| dev_valid_i | input | 1 | Source strobe, asynchronous to clk_i |
| dev_ack_o | output | 1 | Reply: accepted (DEST_INIT=0) or ready-for-data (DEST_INIT=1) |
| cpu_sel_i | input | 1 | Register access select |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | 1 | 0 = data register, 1 = control/status |
| cpu_wdata_i | input | DW | Write data |
| cpu_rdata_o | output | DW | Read data, combinational |
| irq_o | output | 1 | Interrupt request |
| alarm_o | output | 1 | Sticky stall alarm |

## Verification
The exact capture latency is measured with one byte, and the reply is checked on the edge before and the edge after, which separates a correct synchronizer depth from one that is off by a stage. The bench then holds the flag while the source drops its strobe and while it pushes a second byte. It also clears the flag with the strobe still high. These cases tell a reply that waits for software apart from one that follows the strobe, and they show whether a stuck strobe is wrongly taken as a new byte. A polled stream of bytes that are all zeros, all ones, alternating bits and single-bit values passes through a queue-based scoreboard and must cause no alarm. A deliberately stalled phase then checks when the alarm sets, that it stays set, and that the interrupt follows it. A second instance built with the inverted reply is compared against the first.

// File: rtl/hsk_rx_pkg.sv
package hsk_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_HOLD,
    ST_DRAIN
  } hs_state_e;

  localparam int unsigned FLAG_BIT  = 0;
  localparam int unsigned ALARM_BIT = 1;
  localparam int unsigned IE_BIT    = 2;
  localparam int unsigned CSR_BITS  = 3;

  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_CSR  = 1'b1;
endpackage

// File: rtl/hsk_sync.sv
module hsk_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/hsk_fsm.sv
module hsk_fsm
  import hsk_rx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vs_i,
  input  logic flag_i,
  output logic capture_o,
  output logic accepted_o,
  output logic busy_o,
  output logic phase_chg_o
);
  hs_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (vs_i) state_d = ST_SAMPLE;
      ST_SAMPLE: state_d = ST_HOLD;
      ST_HOLD:   if (!flag_i) state_d = vs_i ? ST_DRAIN : ST_IDLE;
      ST_DRAIN:  if (!vs_i) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign capture_o   = (state_q == ST_SAMPLE);
  assign accepted_o  = (state_q == ST_HOLD);
  assign busy_o      = (state_q != ST_IDLE);
  assign phase_chg_o = (state_d != state_q);
endmodule

// File: rtl/hsk_wdog.sv
module hsk_wdog #(
  parameter int unsigned LIMIT = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic restart_i,
  output logic expire_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
  localparam logic [CW-1:0] TOP  = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (!busy_i || restart_i) cnt_q <= '0;
    else if (cnt_q != TOP)         cnt_q <= cnt_q + 1'b1;
  end

  // one pulse per phase, on the edge that completes LIMIT cycles
  assign expire_o = busy_i && !restart_i && (cnt_q == LAST);
endmodule

// File: rtl/hsk_regs.sv
module hsk_regs
  import hsk_rx_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          capture_i,
  input  logic [DW-1:0] data_i,
  input  logic          expire_i,
  input  logic          cpu_sel_i,
  input  logic          cpu_we_i,
  input  logic          cpu_addr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic [DW-1:0] cpu_rdata_o,
  output logic          flag_o,
  output logic          alarm_o,
  output logic          ie_o,
  output logic [DW-1:0] data_o
);
  logic wr_csr;
  logic flag_q, alarm_q, ie_q;
  logic [DW-1:0] data_q;

  assign wr_csr = cpu_sel_i && cpu_we_i && (cpu_addr_i == ADDR_CSR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      alarm_q <= 1'b0;
      ie_q    <= 1'b0;
      data_q  <= '0;
    end else begin
      if (capture_i) begin
        flag_q <= 1'b1;
        data_q <= data_i;
      end else if (wr_csr && cpu_wdata_i[FLAG_BIT]) begin
        flag_q <= 1'b0;
      end
      if (expire_i)                               alarm_q <= 1'b1;
      else if (wr_csr && cpu_wdata_i[ALARM_BIT])  alarm_q <= 1'b0;
      if (wr_csr) ie_q <= cpu_wdata_i[IE_BIT];
    end
  end

  always_comb begin
    cpu_rdata_o = '0;
    if (cpu_sel_i && !cpu_we_i) begin
      if (cpu_addr_i == ADDR_DATA) begin
        cpu_rdata_o = data_q;
      end else begin
        cpu_rdata_o[FLAG_BIT]  = flag_q;
        cpu_rdata_o[ALARM_BIT] = alarm_q;
        cpu_rdata_o[IE_BIT]    = ie_q;
      end
    end
  end

  assign flag_o  = flag_q;
  assign alarm_o = alarm_q;
  assign ie_o    = ie_q;
  assign data_o  = data_q;
endmodule

// File: rtl/hsk_rx_if.sv
module hsk_rx_if
  import hsk_rx_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned TIMEOUT_CYC = 1000,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          DEST_INIT   = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] dev_data_i,
  input  logic          dev_valid_i,
  output logic          dev_ack_o,
  input  logic          cpu_sel_i,
  input  logic          cpu_we_i,
  input  logic          cpu_addr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic [DW-1:0] cpu_rdata_o,
  output logic          irq_o,
  output logic          alarm_o
);
  logic vs, capture, acc, busy, phase_chg, expire;
  logic flag, alarm, ie;
  logic [DW-1:0] data_q;

  hsk_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (dev_valid_i),
    .q_o   (vs)
  );

  hsk_fsm i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vs_i       (vs),
    .flag_i     (flag),
    .capture_o  (capture),
    .accepted_o (acc),
    .busy_o     (busy),
    .phase_chg_o(phase_chg)
  );

  hsk_wdog #(.LIMIT(TIMEOUT_CYC)) i_wdog (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .busy_i   (busy),
    .restart_i(phase_chg),
    .expire_o (expire)
  );

  hsk_regs #(.DW(DW)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .capture_i  (capture),
    .data_i     (dev_data_i),
    .expire_i   (expire),
    .cpu_sel_i  (cpu_sel_i),
    .cpu_we_i   (cpu_we_i),
    .cpu_addr_i (cpu_addr_i),
    .cpu_wdata_i(cpu_wdata_i),
    .cpu_rdata_o(cpu_rdata_o),
    .flag_o     (flag),
    .alarm_o    (alarm),
    .ie_o       (ie),
    .data_o     (data_q)
  );

  if (DEST_INIT) begin : g_ready_pol
    assign dev_ack_o = ~acc;
  end else begin : g_accept_pol
    assign dev_ack_o = acc;
  end

  assign irq_o   = ie && (flag || alarm);
  assign alarm_o = alarm;
endmodule

// File: rtl/hsk_rx_chk.sv
module hsk_rx_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          acc_i,
  input logic          flag_i,
  input logic          alarm_i,
  input logic          ie_i,
  input logic          irq_i,
  input logic [DW-1:0] data_i,
  input logic          cpu_sel_i,
  input logic          cpu_we_i,
  input logic          cpu_addr_i,
  input logic [DW-1:0] cpu_wdata_i
);
  logic wr_csr;
  assign wr_csr = cpu_sel_i && cpu_we_i && cpu_addr_i;

  // R3: reply rises only together with the flag
  p_flag_on_accept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(acc_i) |-> flag_i);

  // R4: reply cannot drop while the flag is still set
  p_ack_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && flag_i |=> acc_i);

  // R4: captured byte frozen while waiting for software
  p_data_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_i |=> $stable(data_i));

  // R8: alarm only clears through its own write bit
  p_alarm_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_i && !(wr_csr && cpu_wdata_i[1]) |=> alarm_i);

  // R9: enabled pending byte requests an interrupt
  p_irq_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ie_i && (flag_i || alarm_i) |-> irq_i);
endmodule

bind hsk_rx_if hsk_rx_chk #(.DW(DW)) i_hsk_rx_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .acc_i      (acc),
  .flag_i     (flag),
  .alarm_i    (alarm),
  .ie_i       (ie),
  .irq_i      (irq_o),
  .data_i     (data_q),
  .cpu_sel_i  (cpu_sel_i),
  .cpu_we_i   (cpu_we_i),
  .cpu_addr_i (cpu_addr_i),
  .cpu_wdata_i(cpu_wdata_i)
);

// File: tb/test_hsk_rx_if.sv
`timescale 1ns/1ps
module test_hsk_rx_if;
  localparam int unsigned DW = 8;
  localparam int unsigned TO = 80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DW-1:0] dev_data = '0;
  logic dev_valid = 1'b0;
  logic ack, rdy;
  logic sel = 1'b0, we = 1'b0, addr = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata, rdata2;
  logic irq, alarm, irq2, alarm2;

  int n_chk = 0;
  int n_fail = 0;
  bit mon_en = 1'b0;
  logic [DW-1:0] exp_q[$];

  always #4 clk = ~clk;

  hsk_rx_if #(.DW(DW), .TIMEOUT_CYC(TO), .DEST_INIT(1'b0)) i_hsk_rx_if (
    .clk_i(clk), .rst_ni(rst_n), .dev_data_i(dev_data), .dev_valid_i(dev_valid),
    .dev_ack_o(ack), .cpu_sel_i(sel), .cpu_we_i(we), .cpu_addr_i(addr),
    .cpu_wdata_i(wdata), .cpu_rdata_o(rdata), .irq_o(irq), .alarm_o(alarm));

  hsk_rx_if #(.DW(DW), .TIMEOUT_CYC(TO), .DEST_INIT(1'b1)) i_hsk_rx_if_rdy (
    .clk_i(clk), .rst_ni(rst_n), .dev_data_i(dev_data), .dev_valid_i(dev_valid),
    .dev_ack_o(rdy), .cpu_sel_i(sel), .cpu_we_i(we), .cpu_addr_i(addr),
    .cpu_wdata_i(wdata), .cpu_rdata_o(rdata2), .irq_o(irq2), .alarm_o(alarm2));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic a, input logic [DW-1:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic cpu_read(input logic a, output logic [DW-1:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  // driver: one full source-side handshake, expected byte queued
  task automatic dev_send(input logic [DW-1:0] b);
    while (ack) @(negedge clk);
    @(negedge clk);
    dev_data = b;
    exp_q.push_back(b);
    @(negedge clk);
    dev_valid = 1'b1;
    while (!ack) @(negedge clk);
    @(negedge clk);
    dev_valid = 1'b0;
  endtask

  // monitor: poll flag, read byte, compare, release
  initial begin
    logic [DW-1:0] st, d, e;
    forever begin
      @(negedge clk);
      if (mon_en) begin
        cpu_read(1'b1, st);
        if (st[0]) begin
          cpu_read(1'b0, d);
          if (exp_q.size() == 0) begin
            check("R2 unexpected byte", 32'(d), 32'hFFFF);
          end else begin
            e = exp_q.pop_front();
            check("R2 stream byte", 32'(d), 32'(e));
          end
          cpu_write(1'b1, 8'h01);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] st, d;
    logic [DW-1:0] pat [8];
    pat = '{8'h00, 8'hFF, 8'h55, 8'hAA, 8'h01, 8'h80, 8'h7E, 8'h81};

    repeat (3) @(negedge clk);
    check("R1 ack", 32'(ack), 0);
    check("R10 ready in reset", 32'(rdy), 1);
    rst_n = 1'b1;
    repeat (100) @(negedge clk);
    check("R1 alarm", 32'(alarm), 0);
    check("R7 idle no alarm", 32'(alarm), 0);
    check("R1 irq", 32'(irq), 0);
    cpu_read(1'b1, st);
    check("R1 csr", 32'(st), 0);

    // R2 latency
    @(negedge clk); dev_data = 8'hA5;
    @(negedge clk); dev_valid = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 ack before 4th edge", 32'(ack), 0);
    @(posedge clk);
    @(negedge clk);
    check("R2 ack on 4th edge", 32'(ack), 1);
    check("R10 ready low while held", 32'(rdy), 0);
    cpu_read(1'b1, st);
    check("R3 flag set", 32'(st[0]), 1);
    cpu_read(1'b0, d);
    check("R2 data captured", 32'(d), 32'hA5);

    // R4 hold while flag set
    dev_valid = 1'b0;
    repeat (5) @(negedge clk);
    check("R4 ack held after strobe low", 32'(ack), 1);
    dev_data = 8'h3C; dev_valid = 1'b1;
    repeat (6) @(negedge clk);
    cpu_read(1'b0, d);
    check("R4 no overwrite", 32'(d), 32'hA5);
    dev_valid = 1'b0;

    // R9 / R11 enable
    check("R9 irq off without enable", 32'(irq), 0);
    cpu_write(1'b1, 8'h04);
    check("R9 irq with enable", 32'(irq), 1);
    cpu_read(1'b1, st);
    check("R11 csr map", 32'(st), 32'h05);

    // R5 clear
    cpu_write(1'b1, 8'h05);
    @(posedge clk); @(negedge clk);
    check("R5 ack drops", 32'(ack), 0);
    check("R10 ready back", 32'(rdy), 1);
    check("R9 irq follows flag", 32'(irq), 0);

    // R6 strobe stuck across clear
    repeat (4) @(negedge clk);
    dev_data = 8'h11;
    @(negedge clk); dev_valid = 1'b1;
    while (!ack) @(negedge clk);
    cpu_write(1'b1, 8'h05);
    @(posedge clk); @(negedge clk);
    check("R6 ack drops with strobe high", 32'(ack), 0);
    repeat (10) @(negedge clk);
    cpu_read(1'b1, st);
    check("R6 no recapture", 32'(st[0]), 0);
    cpu_read(1'b0, d);
    check("R6 data kept", 32'(d), 32'h11);
    dev_valid = 1'b0;
    repeat (4) @(negedge clk);
    dev_data = 8'h22;
    @(negedge clk); dev_valid = 1'b1;
    while (!ack) @(negedge clk);
    @(negedge clk); dev_valid = 1'b0;
    cpu_read(1'b0, d);
    check("R6 next byte after low", 32'(d), 32'h22);
    cpu_write(1'b1, 8'h05);
    while (ack) @(negedge clk);
    check("R7 no alarm in normal flow", 32'(alarm), 0);

    // R7 stalled phase
    repeat (3) @(negedge clk);
    dev_data = 8'h33;
    @(negedge clk); dev_valid = 1'b1;
    while (!ack) @(negedge clk);
    dev_valid = 1'b0;
    repeat (78) @(negedge clk);
    check("R7 alarm not early", 32'(alarm), 0);
    repeat (3) @(negedge clk);
    check("R7 alarm on stall", 32'(alarm), 1);
    check("R9 irq with alarm", 32'(irq), 1);

    // R8 sticky
    cpu_write(1'b1, 8'h05);
    repeat (3) @(negedge clk);
    check("R8 alarm survives flag clear", 32'(alarm), 1);
    check("R9 irq from alarm only", 32'(irq), 1);
    cpu_write(1'b1, 8'h06);
    check("R8 alarm cleared", 32'(alarm), 0);
    check("R9 irq off", 32'(irq), 0);

    // R11 ignored write / idle bus
    cpu_write(1'b0, 8'hFF);
    cpu_read(1'b0, d);
    check("R11 data write ignored", 32'(d), 32'h33);
    @(negedge clk);
    check("R11 rdata idle", 32'(rdata), 0);

    // scoreboard stream
    cpu_write(1'b1, 8'h00);
    mon_en = 1'b1;
    foreach (pat[i]) dev_send(pat[i]);
    for (int k = 0; k < 2000 && exp_q.size() != 0; k++) @(negedge clk);
    repeat (20) @(negedge clk);
    mon_en = 1'b0;
    repeat (10) @(negedge clk);
    check("R2 stream drained", 32'(exp_q.size()), 0);
    check("R7 no alarm in stream", 32'(alarm), 0);
    check("R10 idle ready", 32'(rdy), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule